// File: doc/BRIEF.md
# Random-Pattern Memory Test Sequencer

This block is a self-running memory test engine. It sweeps an address window once to fill memory with a pseudo-random pattern. It then sweeps the same window a second time, reads every word back and checks it against the same pattern, which it regenerates. It repeats this write-and-verify cycle with fresh data until it is told to stop, or until it halts on a failure.

Each word is 40 bits wide. Bits 39:4 hold a random value. Bits 3:0 hold the inverse of that value's lowest four bits, so a stuck nibble in the narrow field shows up against random data in the wide field. Both fields are compared under separate masks and flagged separately. The first failure freezes a capture of the address, the data read and the data expected.

The engine drives a plain synchronous memory port. Reads have a fixed latency of one cycle, and there is no back-pressure: the memory must accept one request every cycle. Two trigger outputs pulse when the sweep reaches a chosen address, one for the write sweep and one for the read sweep. They are meant for arming external capture equipment. All configuration is sampled at start and held for the whole run.

Top module: `mem_rand_tester`

## Requirements
- R1: Each sweep visits addresses in ascending order. It begins at the low bound and adds the step, where a step of 0 is treated as 1. The sweep ends after the address whose successor would exceed the high bound, so the low bound is always visited.
- R2: Write data is {r, ~r[3:0]}: r occupies bits 39:4 and the inverted nibble occupies bits 3:0. Successive r values follow s' = (s >> 1) ^ (s[0] ? 36'h801000000 : 0). Every accepted start restarts the sequence at the seed 36'h0A5A5A5A5.
- R3: trig_wr is high for exactly the cycles in which mem_we is high and mem_addr equals the write-watch address.
- R4: trig_rd is high for exactly the cycles in which mem_re is high and mem_addr equals the read-watch address.
- R5: The read sweep issues one read per cycle. mem_rdata is compared one cycle after the request against the sequence the write sweep used, so fault-free memory never raises an error.
- R6: A bit that is 0 in cfg_mask_hi (bits 39:4) or in cfg_mask_lo (bits 3:0) never causes a mismatch.
- R7: fail_hi and fail_lo are sticky flags for the wide field and the narrow field, set independently. err_sticky is their OR. Only an accepted start clears them.
- R8: The first mismatch after a start captures the address, both fields of the read data and both fields of the expected data. Later mismatches do not change the capture.
- R9: If halt_on_err is set, busy falls in the cycle after the mismatching compare. If it is clear, the engine keeps running.
- R10: iter_count increments by one after each completed write-plus-read round and is cleared by an accepted start. The next round continues the random sequence, so it writes different data.
- R11: When stop is sampled high, busy is low from the next cycle, and no further writes or reads are issued.
- R12: start is ignored while busy. Configuration inputs are sampled only when a start is accepted.
- R13: mem_we and mem_re are never high together. While idle, mem_we, mem_re, trig_wr and trig_rd are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| stop | input | 1 | Abort the run |
| halt_on_err | input | 1 | Halt on the first mismatch |
| cfg_low | input | AW | Low address bound |
| cfg_high | input | AW | High address bound |
| cfg_step | input | AW | Address increment |
| cfg_wwatch | input | AW | Write-sweep trigger address |
| cfg_rwatch | input | AW | Read-sweep trigger address |
| cfg_mask_hi | input | 36 | Compare mask for bits 39:4 |
| cfg_mask_lo | input | 4 | Compare mask for bits 3:0 |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read request |
| mem_wdata | output | 40 | Memory write data |
| mem_rdata | input | 40 | Memory read data, valid one cycle after mem_re |
| trig_wr | output | 1 | Write-watch trigger pulse |
| trig_rd | output | 1 | Read-watch trigger pulse |
| busy | output | 1 | Engine is running |
| err_sticky | output | 1 | Any mismatch since start |
| fail_hi | output | 1 | Wide-field mismatch since start |
| fail_lo | output | 1 | Narrow-field mismatch since start |
| fail_addr | output | AW | Address of first mismatch |
| fail_rd_hi | output | 36 | Read wide field at first mismatch |
| fail_rd_lo | output | 4 | Read narrow field at first mismatch |
| fail_exp_hi | output | 36 | Expected wide field at first mismatch |
| fail_exp_lo | output | 4 | Expected narrow field at first mismatch |
| iter_count | output | CW | Completed rounds |

## Verification
The checker watches the cycle-level rules on every clock:
- write and read requests are never issued together;
- the outputs are quiet while idle;
- a trigger fires only alongside its own kind of request;
- write addresses only ascend within a sweep;
- stop and halt take effect in the next cycle;
- the error flags hold their value;
- the round counter moves only by one.

Some properties need a memory and a reference sequence, so only the directed scenarios can show them:
- that the data follows the stated sequence;
- that the read sweep really replays the write sweep;
- that masks hide injected faults;
- that the capture registers hold the right address and values.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int HI_W   = 36;
  localparam int LO_W   = 4;
  localparam int WORD_W = HI_W + LO_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_DRAIN = 2'd3
  } mrt_state_e;

  typedef struct packed {
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
  } mrt_word_t;

  // Wide field carries the random value; narrow field carries its inverted low bits.
  function automatic mrt_word_t mrt_make_word(input logic [HI_W-1:0] r);
    mrt_word_t w;
    w.hi = r;
    w.lo = ~r[LO_W-1:0];
    return w;
  endfunction
endpackage

// File: rtl/mrt_lfsr.sv
module mrt_lfsr #(
  parameter int           W     = 36,
  parameter logic [W-1:0] SEED  = '1,
  parameter logic [W-1:0] TAPS  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_seed,
  input  logic         save,
  input  logic         restore,
  input  logic         advance,
  output logic [W-1:0] value
);
  logic [W-1:0] state_q;
  logic [W-1:0] ckpt_q;
  logic [W-1:0] next_c;

  // Right-shifting Galois form: feedback folds in wherever TAPS has a one.
  always_comb begin
    next_c = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEED;
      ckpt_q  <= SEED;
    end else begin
      if (load_seed)    state_q <= SEED;
      else if (restore) state_q <= ckpt_q;
      else if (advance) state_q <= next_c;

      if (load_seed)    ckpt_q <= SEED;
      else if (save)    ckpt_q <= state_q;
    end
  end

  assign value = state_q;
endmodule

// File: rtl/mrt_addr_walk.sv
module mrt_addr_walk #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] low,
  input  logic [AW-1:0] high,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] addr_q;
  logic [AW-1:0] step_eff;
  logic [AW:0]   sum_c;

  assign step_eff = (step == '0) ? ONE : step;
  // One extra bit so a step past the top of the address space counts as beyond the bound.
  assign sum_c    = {1'b0, addr_q} + {1'b0, step_eff};
  assign last     = sum_c > {1'b0, high};

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (load)    addr_q <= low;
    else if (advance) addr_q <= sum_c[AW-1:0];
  end

  assign addr = addr_q;
endmodule

// File: rtl/mrt_compare.sv
module mrt_compare
  import mrt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            issue,
  input  logic [AW-1:0]   issue_addr,
  input  mrt_word_t       issue_exp,
  input  mrt_word_t       rd_word,
  input  logic [HI_W-1:0] mask_hi,
  input  logic [LO_W-1:0] mask_lo,
  output logic            mismatch,
  output logic            fail_hi,
  output logic            fail_lo,
  output logic [AW-1:0]   fail_addr,
  output logic [HI_W-1:0] fail_rd_hi,
  output logic [LO_W-1:0] fail_rd_lo,
  output logic [HI_W-1:0] fail_exp_hi,
  output logic [LO_W-1:0] fail_exp_lo
);
  logic          pend_q;
  logic [AW-1:0] pend_addr_q;
  mrt_word_t     pend_exp_q;
  logic          bad_hi;
  logic          bad_lo;
  logic          first_err;

  // The read data returns one cycle after the request; the expected word waits here for it.
  assign bad_hi    = pend_q && |((rd_word.hi ^ pend_exp_q.hi) & mask_hi);
  assign bad_lo    = pend_q && |((rd_word.lo ^ pend_exp_q.lo) & mask_lo);
  assign mismatch  = bad_hi || bad_lo;
  assign first_err = mismatch && !(fail_hi || fail_lo);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_exp_q  <= '0;
      fail_hi     <= 1'b0;
      fail_lo     <= 1'b0;
      fail_addr   <= '0;
      fail_rd_hi  <= '0;
      fail_rd_lo  <= '0;
      fail_exp_hi <= '0;
      fail_exp_lo <= '0;
    end else begin
      pend_q <= issue;
      if (issue) begin
        pend_addr_q <= issue_addr;
        pend_exp_q  <= issue_exp;
      end
      if (bad_hi) fail_hi <= 1'b1;
      if (bad_lo) fail_lo <= 1'b1;
      if (first_err) begin
        fail_addr   <= pend_addr_q;
        fail_rd_hi  <= rd_word.hi;
        fail_rd_lo  <= rd_word.lo;
        fail_exp_hi <= pend_exp_q.hi;
        fail_exp_lo <= pend_exp_q.lo;
      end
    end
  end
endmodule

// File: rtl/mem_rand_tester.sv
module mem_rand_tester
  import mrt_pkg::*;
#(
  parameter int              AW   = 16,
  parameter int              CW   = 16,
  parameter logic [HI_W-1:0] SEED = 36'h0A5A5A5A5,
  parameter logic [HI_W-1:0] TAPS = 36'h801000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              halt_on_err,
  input  logic [AW-1:0]     cfg_low,
  input  logic [AW-1:0]     cfg_high,
  input  logic [AW-1:0]     cfg_step,
  input  logic [AW-1:0]     cfg_wwatch,
  input  logic [AW-1:0]     cfg_rwatch,
  input  logic [HI_W-1:0]   cfg_mask_hi,
  input  logic [LO_W-1:0]   cfg_mask_lo,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              trig_wr,
  output logic              trig_rd,
  output logic              busy,
  output logic              err_sticky,
  output logic              fail_hi,
  output logic              fail_lo,
  output logic [AW-1:0]     fail_addr,
  output logic [HI_W-1:0]   fail_rd_hi,
  output logic [LO_W-1:0]   fail_rd_lo,
  output logic [HI_W-1:0]   fail_exp_hi,
  output logic [LO_W-1:0]   fail_exp_lo,
  output logic [CW-1:0]     iter_count
);
  mrt_state_e      state_q, state_d;
  logic [AW-1:0]   low_q, high_q, step_q, ww_q, rw_q;
  logic [HI_W-1:0] mask_hi_q;
  logic [LO_W-1:0] mask_lo_q;
  logic            halt_q;
  logic [CW-1:0]   iter_q;

  logic            start_acc;
  logic            in_write, in_read, in_drain;
  logic            walk_last, walk_load, walk_adv;
  logic [AW-1:0]   walk_addr;
  logic            lf_save, lf_restore, lf_adv;
  logic [HI_W-1:0] lf_value;
  mrt_word_t       pat_word;
  mrt_word_t       rd_word;
  logic            cmp_bad;
  logic            halt_now;

  assign start_acc = start && (state_q == ST_IDLE);
  assign in_write  = (state_q == ST_WRITE);
  assign in_read   = (state_q == ST_READ);
  assign in_drain  = (state_q == ST_DRAIN);
  assign halt_now  = halt_q && cmp_bad;

  // Configuration is sampled once per accepted start and held for the run.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q     <= '0;
      high_q    <= '0;
      step_q    <= '0;
      ww_q      <= '0;
      rw_q      <= '0;
      mask_hi_q <= '1;
      mask_lo_q <= '1;
      halt_q    <= 1'b0;
    end else if (start_acc) begin
      low_q     <= cfg_low;
      high_q    <= cfg_high;
      step_q    <= cfg_step;
      ww_q      <= cfg_wwatch;
      rw_q      <= cfg_rwatch;
      mask_hi_q <= cfg_mask_hi;
      mask_lo_q <= cfg_mask_lo;
      halt_q    <= halt_on_err;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_WRITE;
      ST_WRITE: begin
        if (stop || halt_now) state_d = ST_IDLE;
        else if (walk_last)   state_d = ST_READ;
      end
      ST_READ: begin
        if (stop || halt_now) state_d = ST_IDLE;
        else if (walk_last)   state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (stop || halt_now) state_d = ST_IDLE;
        else                  state_d = ST_WRITE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_acc)                            iter_q <= '0;
      else if (in_drain && state_d == ST_WRITE) iter_q <= iter_q + 1'b1;
    end
  end

  // The address goes back to the low bound at start, between the two sweeps, and between rounds.
  assign walk_load  = start_acc || (in_write && walk_last) || in_drain;
  assign walk_adv   = in_write || in_read;

  // Generator: save at the start of each write sweep, restore for the read sweep.
  assign lf_save    = in_drain;
  assign lf_restore = in_write && walk_last;
  assign lf_adv     = (in_write && !walk_last) || in_read;

  mrt_addr_walk #(.AW(AW)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (walk_load),
    .advance (walk_adv),
    .low     (start_acc ? cfg_low : low_q),
    .high    (high_q),
    .step    (step_q),
    .addr    (walk_addr),
    .last    (walk_last)
  );

  mrt_lfsr #(.W(HI_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_seed (start_acc),
    .save      (lf_save),
    .restore   (lf_restore),
    .advance   (lf_adv),
    .value     (lf_value)
  );

  assign pat_word = mrt_make_word(lf_value);
  assign rd_word  = mrt_word_t'(mem_rdata);

  mrt_compare #(.AW(AW)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start_acc),
    .issue       (in_read),
    .issue_addr  (walk_addr),
    .issue_exp   (pat_word),
    .rd_word     (rd_word),
    .mask_hi     (mask_hi_q),
    .mask_lo     (mask_lo_q),
    .mismatch    (cmp_bad),
    .fail_hi     (fail_hi),
    .fail_lo     (fail_lo),
    .fail_addr   (fail_addr),
    .fail_rd_hi  (fail_rd_hi),
    .fail_rd_lo  (fail_rd_lo),
    .fail_exp_hi (fail_exp_hi),
    .fail_exp_lo (fail_exp_lo)
  );

  assign mem_we     = in_write;
  assign mem_re     = in_read;
  assign mem_addr   = (in_write || in_read) ? walk_addr : '0;
  assign mem_wdata  = in_write ? pat_word : '0;
  assign trig_wr    = in_write && (walk_addr == ww_q);
  assign trig_rd    = in_read && (walk_addr == rw_q);
  assign busy       = (state_q != ST_IDLE);
  assign err_sticky = fail_hi || fail_lo;
  assign iter_count = iter_q;
endmodule

// File: rtl/mrt_chk.sv
module mrt_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stop,
  input logic          halt_on_err,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic          trig_wr,
  input logic          trig_rd,
  input logic          busy,
  input logic          err_sticky,
  input logic [CW-1:0] iter_count
);
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R13

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re && !trig_wr && !trig_rd)); // R13

  AST_TRIG_WR_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |-> mem_we); // R3

  AST_TRIG_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> !trig_wr); // R3

  AST_TRIG_RD_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rd |-> mem_re); // R4

  AST_TRIG_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rd |=> !trig_rd); // R4

  AST_WR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr > $past(mem_addr))); // R1

  AST_STOP_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> !busy); // R11

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !start) |=> err_sticky); // R7

  AST_ITER_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_count != $past(iter_count)) |->
      (iter_count == $past(iter_count) + 1'b1 || iter_count == '0)); // R10

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_on_err && $rose(err_sticky)) |-> !busy); // R9
endmodule

bind mem_rand_tester mrt_chk #(.AW(AW), .CW(CW)) u_mrt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .stop        (stop),
  .halt_on_err (halt_on_err),
  .mem_addr    (mem_addr),
  .mem_we      (mem_we),
  .mem_re      (mem_re),
  .trig_wr     (trig_wr),
  .trig_rd     (trig_rd),
  .busy        (busy),
  .err_sticky  (err_sticky),
  .iter_count  (iter_count)
);

// File: tb/sim_mem_rand_tester.sv
`timescale 1ns/1ps
module sim_mem_rand_tester;
  localparam int AW  = 8;
  localparam int CW  = 16;
  localparam int HW  = 36;
  localparam int LW  = 4;
  localparam int WW  = 40;
  localparam int LOG = 256;
  localparam logic [HW-1:0] SEED_V = 36'h0A5A5A5A5;
  localparam logic [HW-1:0] TAP_V  = 36'h801000000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          stop = 1'b0;
  logic          halt_on_err = 1'b0;
  logic [AW-1:0] cfg_low = '0, cfg_high = '0, cfg_step = '0, cfg_wwatch = '0, cfg_rwatch = '0;
  logic [HW-1:0] cfg_mask_hi = '1;
  logic [LW-1:0] cfg_mask_lo = '1;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re;
  logic [WW-1:0] mem_wdata;
  logic [WW-1:0] mem_rdata = '0;
  logic          trig_wr, trig_rd, busy, err_sticky, fail_hi, fail_lo;
  logic [AW-1:0] fail_addr;
  logic [HW-1:0] fail_rd_hi, fail_exp_hi;
  logic [LW-1:0] fail_rd_lo, fail_exp_lo;
  logic [CW-1:0] iter_count;

  always #2.5 clk = ~clk;

  mem_rand_tester #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .halt_on_err(halt_on_err),
    .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_step(cfg_step),
    .cfg_wwatch(cfg_wwatch), .cfg_rwatch(cfg_rwatch),
    .cfg_mask_hi(cfg_mask_hi), .cfg_mask_lo(cfg_mask_lo),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .trig_wr(trig_wr), .trig_rd(trig_rd), .busy(busy), .err_sticky(err_sticky),
    .fail_hi(fail_hi), .fail_lo(fail_lo), .fail_addr(fail_addr),
    .fail_rd_hi(fail_rd_hi), .fail_rd_lo(fail_rd_lo),
    .fail_exp_hi(fail_exp_hi), .fail_exp_lo(fail_exp_lo),
    .iter_count(iter_count)
  );

  // Memory model with optional read-side fault injection.
  logic [WW-1:0] mem_arr [0:(1<<AW)-1];
  logic          flt_en = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [WW-1:0] flt_mask = '0;

  always @(posedge clk) begin
    if (mem_we) mem_arr[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem_arr[mem_addr] ^ ((flt_en && mem_addr == flt_addr) ? flt_mask : '0);
  end

  // Port monitor.
  logic [AW-1:0] wl_addr [0:LOG-1];
  logic [WW-1:0] wl_data [0:LOG-1];
  int wr_n, rd_n, tw_n, tr_n, tw_bad, tr_bad;
  logic [AW-1:0] b_ww, b_rw;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (wr_n < LOG) begin
          wl_addr[wr_n] = mem_addr;
          wl_data[wr_n] = mem_wdata;
        end
        wr_n++;
      end
      if (mem_re) rd_n++;
      if (trig_wr) tw_n++;
      if (trig_rd) tr_n++;
      if (trig_wr != (mem_we && mem_addr == b_ww)) tw_bad++;
      if (trig_rd != (mem_re && mem_addr == b_rw)) tr_bad++;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] nxt(input logic [HW-1:0] s);
    return {1'b0, s[HW-1:1]} ^ (s[0] ? TAP_V : '0);
  endfunction

  function automatic logic [HW-1:0] model_val(input int idx);
    logic [HW-1:0] s = SEED_V;
    for (int i = 0; i < idx; i++) s = nxt(s);
    return s;
  endfunction

  function automatic logic [WW-1:0] model_word(input int idx);
    logic [HW-1:0] v = model_val(idx);
    return {v, ~v[LW-1:0]};
  endfunction

  task automatic start_run(input logic [AW-1:0] lo, input logic [AW-1:0] hi, input logic [AW-1:0] st,
                           input logic [AW-1:0] ww, input logic [AW-1:0] rw,
                           input logic [HW-1:0] mh, input logic [LW-1:0] ml, input logic halt);
    cfg_low = lo; cfg_high = hi; cfg_step = st; cfg_wwatch = ww; cfg_rwatch = rw;
    cfg_mask_hi = mh; cfg_mask_lo = ml; halt_on_err = halt;
    b_ww = ww; b_rw = rw;
    wr_n = 0; rd_n = 0; tw_n = 0; tr_n = 0; tw_bad = 0; tr_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_iter(input int n);
    int t = 0;
    while (iter_count < n && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic end_run();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R13 reset busy", busy, 0);
    chk(!mem_we && !mem_re, "R13 reset no requests", {mem_we, mem_re}, 0);
    chk(!trig_wr && !trig_rd, "R13 reset triggers", {trig_wr, trig_rd}, 0);
    chk(err_sticky == 1'b0, "R7 reset error flag", err_sticky, 0);
    chk(iter_count == 0, "R10 reset round count", iter_count, 0);
  endtask

  task automatic t_basic_rounds();
    int bad_a = 0, bad_d = 0;
    start_run(8'd4, 8'd11, 8'd1, 8'd6, 8'd9, '1, '1, 1'b0);
    wait_iter(2);
    end_run();
    chk(busy == 1'b0, "R11 busy after stop", busy, 0);
    chk(!mem_we && !mem_re, "R11 no requests after stop", {mem_we, mem_re}, 0);
    chk(iter_count == 2, "R10 two rounds counted", iter_count, 2);
    for (int k = 0; k < 16; k++) begin
      if (wl_addr[k] != AW'(4 + (k % 8))) bad_a++;
      if (wl_data[k] != model_word(k)) bad_d++;
    end
    chk(wr_n >= 16 && bad_a == 0, "R1 unit step address order", bad_a, 0);
    chk(bad_d == 0, "R2 write data sequence", bad_d, 0);
    chk(wl_data[0] != wl_data[8], "R10 fresh data next round", wl_data[8], wl_data[0]);
    chk(err_sticky == 1'b0 && rd_n >= 16, "R5 clean readback", {err_sticky, 32'(rd_n)}, 16);
    chk(tw_n >= 2 && tw_bad == 0, "R3 write trigger", {32'(tw_n), 32'(tw_bad)}, {32'd2, 32'd0});
    chk(tr_n >= 2 && tr_bad == 0, "R4 read trigger", {32'(tr_n), 32'(tr_bad)}, {32'd2, 32'd0});
  endtask

  task automatic t_steps();
    int bad = 0;
    start_run(8'd2, 8'd20, 8'd3, 8'd5, 8'd8, '1, '1, 1'b0);
    @(negedge clk);
    cfg_low = 8'd0; cfg_high = 8'd200; cfg_step = 8'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_iter(1);
    end_run();
    for (int k = 0; k < 8; k++) if (wl_addr[k] != AW'(2 + 3 * (k % 7))) bad++;
    chk(wr_n >= 8 && bad == 0, "R1 step three ending on bound", bad, 0);
    chk(bad == 0 && iter_count == 1, "R12 start while busy ignored", iter_count, 1);
    chk(tw_bad == 0 && tr_bad == 0, "R3 R4 triggers with stride", tw_bad + tr_bad, 0);

    bad = 0;
    start_run(8'd0, 8'd10, 8'd4, 8'd0, 8'd0, '1, '1, 1'b0);
    wait_iter(1);
    end_run();
    for (int k = 0; k < 4; k++) if (wl_addr[k] != AW'(4 * (k % 3))) bad++;
    chk(wr_n >= 4 && bad == 0, "R1 bound between strides", bad, 0);

    bad = 0;
    start_run(8'd5, 8'd7, 8'd0, 8'd0, 8'd0, '1, '1, 1'b0);
    wait_iter(1);
    end_run();
    for (int k = 0; k < 4; k++) if (wl_addr[k] != AW'(5 + (k % 3))) bad++;
    chk(wr_n >= 4 && bad == 0, "R1 zero step acts as one", bad, 0);
  endtask

  task automatic t_fault_hi();
    logic [HW-1:0] ev = model_val(7);
    flt_en = 1'b1; flt_addr = 8'd17; flt_mask = 40'h1 << 24;
    start_run(8'd10, 8'd30, 8'd1, 8'd0, 8'd0, '1, '1, 1'b1);
    wait_idle();
    flt_en = 1'b0;
    chk(busy == 1'b0 && rd_n == 9, "R9 halt after mismatch", rd_n, 9);
    chk(fail_hi && !fail_lo && err_sticky, "R7 wide field flag only", {fail_hi, fail_lo}, 2'b10);
    chk(fail_addr == 8'd17, "R8 captured address", fail_addr, 17);
    chk(fail_exp_hi == ev, "R8 captured expected wide", fail_exp_hi, ev);
    chk(fail_rd_hi == (ev ^ (36'h1 << 20)), "R8 captured read wide", fail_rd_hi, ev ^ (36'h1 << 20));
    chk(fail_rd_lo == ~ev[3:0] && fail_exp_lo == ~ev[3:0], "R8 captured narrow fields",
        {fail_rd_lo, fail_exp_lo}, {~ev[3:0], ~ev[3:0]});
  endtask

  task automatic t_fault_lo();
    logic [HW-1:0] ev = model_val(2);
    flt_en = 1'b1; flt_addr = 8'd12; flt_mask = 40'h2;
    start_run(8'd10, 8'd30, 8'd1, 8'd0, 8'd0, '1, '1, 1'b1);
    wait_idle();
    flt_en = 1'b0;
    chk(fail_lo && !fail_hi, "R7 narrow field flag only", {fail_hi, fail_lo}, 2'b01);
    chk(fail_rd_lo == (~ev[3:0] ^ 4'h2), "R8 captured read narrow", fail_rd_lo, ~ev[3:0] ^ 4'h2);
  endtask

  task automatic t_masks();
    flt_en = 1'b1; flt_addr = 8'd12; flt_mask = 40'h1000001;
    start_run(8'd10, 8'd20, 8'd1, 8'd0, 8'd0, ~(36'h1 << 20), 4'hE, 1'b1);
    wait_iter(1);
    end_run();
    flt_en = 1'b0;
    chk(err_sticky == 1'b0 && iter_count == 1, "R6 masked bits ignored", err_sticky, 0);
  endtask

  task automatic t_no_halt();
    flt_en = 1'b1; flt_addr = 8'd12; flt_mask = 40'h1 << 24;
    start_run(8'd10, 8'd15, 8'd1, 8'd0, 8'd0, '1, '1, 1'b0);
    wait_iter(2);
    chk(busy == 1'b1 && iter_count == 2, "R9 keeps running without halt", iter_count, 2);
    chk(err_sticky && fail_addr == 8'd12, "R8 first capture kept", fail_addr, 12);
    end_run();
    flt_en = 1'b0;
    chk(err_sticky == 1'b1, "R7 flag survives stop", err_sticky, 1);
    start_run(8'd10, 8'd15, 8'd1, 8'd0, 8'd0, '1, '1, 1'b0);
    chk(err_sticky == 1'b0 && !fail_hi, "R7 start clears flags", err_sticky, 0);
    chk(iter_count == 0, "R10 start clears round count", iter_count, 0);
    end_run();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_rounds();
    t_steps();
    t_fault_hi();
    t_fault_lo();
    t_masks();
    t_no_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule